// File: doc/BRIEF.md
# Multi-Mode I2C Target Address Matcher

This block decides whether the address phase of an I2C transfer selects this target. A bit-level front end, outside this block, assembles the bytes that follow a Start or Restart condition and presents each one with a single-cycle strobe. It also marks every Start or Restart with its own pulse. The matcher compares those bytes against four 8-bit configuration registers. A two-bit mode select decides how the four registers are read. They can be four independent 7-bit addresses, or two address/mask pairs for 7-bit addressing. They can also be two 10-bit addresses split into low and high bytes, or one 10-bit address whose low and high bytes each have a mask register.

On a hit the block raises a one-cycle match pulse and reports which address entry was selected. It copies the received R/W bit into a read flag. It also stores the matched address bytes, either in two address buffers or in the receive data register, as chosen by a steering input. In 10-bit modes the high byte is checked first. A miss on the high byte abandons the transfer until the next Start or Restart.

Top module: `i2c_tgt_addr_match`

## Requirements
- R1: After reset, and at any time before the first Start, received bytes raise no match and change no output.
- R2: In mode 00 (plain 7-bit), the first byte after a Start matches entry k when byte bits 7:1 equal register k bits 7:1. Register bit 0 is not used. The lowest matching k, from 0 to 3, is reported on slot_o.
- R3: In mode 01 (masked 7-bit), register 0 is an address and register 1 is its mask, and together they form entry 0. Registers 2 and 3 form entry 1 in the same way. A mask bit of 0 excludes that address bit (bits 7:1) from the comparison. Entry 0 wins when both entries hit.
- R4: In both 7-bit modes, only the first byte after a Start or Restart is compared. On a hit, its bit 0 is copied to rd_o. Later bytes are ignored until the next Start or Restart.
- R5: In mode 10 (10-bit), the first byte is the high byte. Its bits 7:1 are compared as stored against bits 7:1 of register 1 (entry 0) and register 3 (entry 1). No prefix is inserted. The second byte must then equal register 0 or register 2, all 8 bits, for an entry whose high byte matched. slot_o gives the entry, with entry 0 winning.
- R6: In mode 11 (masked 10-bit), the high byte is compared with register 1 bits 7:1 under mask register 3. The low byte is compared with register 0 under mask register 2, where a mask bit of 0 means don't-care. slot_o is 0.
- R7: In 10-bit modes, a high-byte miss ends the transfer. The following low byte is ignored: there is no match and nothing is captured.
- R8: In 10-bit modes, a high-byte hit captures the high byte and copies its bit 0 to rd_o, even if the low byte then misses.
- R9: With dir_i = 0, a captured 7-bit byte or 10-bit low byte goes to abuf0_o, and a 10-bit high byte goes to abuf1_o, while rxd_o holds. With dir_i = 1, every captured byte goes to rxd_o, while abuf0_o and abuf1_o hold.
- R10: match_o is a one-cycle pulse in the cycle after the strobe of the deciding byte. slot_o is valid in that cycle and holds its value otherwise.
- R11: A Start or Restart at any point restarts address matching with the next byte. A byte strobed in the same cycle as a Start is ignored.
- R12: Reset clears match_o, slot_o, rd_o, abuf0_o, abuf1_o and rxd_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start or Restart seen (one-cycle pulse) |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| mode_i | input | 2 | 00 plain 7-bit, 01 masked 7-bit, 10 10-bit, 11 masked 10-bit |
| dir_i | input | 1 | Capture steering: 0 address buffers, 1 receive data register |
| cfg0_i | input | 8 | Address configuration register 0 |
| cfg1_i | input | 8 | Address configuration register 1 |
| cfg2_i | input | 8 | Address configuration register 2 |
| cfg3_i | input | 8 | Address configuration register 3 |
| match_o | output | 1 | Address match pulse |
| slot_o | output | 2 | Index of the matched entry |
| rd_o | output | 1 | Received R/W bit of the address |
| abuf0_o | output | 8 | Address buffer for the 7-bit or low address byte |
| abuf1_o | output | 8 | Address buffer for the 10-bit high address byte |
| rxd_o | output | 8 | Receive data register |

## Verification
The assertions check several rules on every cycle. The match pulse never lasts two cycles and always follows an accepted byte. The sequencer stays quiet while idle or finished, and a Start always returns it to the first-byte state. The destination not chosen by the steering flag never moves, and the reported entry index stays within range for each mode. Only the bench scenarios can show that the right entry is selected. They cover mask don't-care bits, the priority between entries, 10-bit high-byte aborts, a Restart in the middle of a 10-bit sequence, and the exact byte and R/W values captured under both steering settings.

// File: rtl/am_pkg.sv
package am_pkg;
  localparam int BYTE_W = 8;
  localparam int NCFG   = 4;

  typedef enum logic [1:0] {
    MODE_7B      = 2'b00,
    MODE_7B_MASK = 2'b01,
    MODE_10B     = 2'b10,
    MODE_10B_MASK= 2'b11
  } am_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_LOW   = 2'd2,
    ST_DONE  = 2'd3
  } am_state_e;
endpackage

// File: rtl/am_cmp_bank.sv
module am_cmp_bank
  import am_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NC = NCFG,
  localparam int NPAIR = NC / 2
) (
  input  logic [1:0]             mode_i,
  input  logic [BW-1:0]          byte_i,
  input  logic [NC-1:0][BW-1:0]  cfg_i,
  output logic                   is10_o,
  output logic [NC-1:0]          first_hit_o,
  output logic [NPAIR-1:0]       low_hit_o
);
  // address bits of a 7-bit byte or 10-bit high byte; bit 0 is R/W
  localparam logic [BW-1:0] ADDR_BITS = {{(BW-1){1'b1}}, 1'b0};

  logic [NC-1:0]    plain7;
  logic [NPAIR-1:0] mask7;
  logic [NPAIR-1:0] hi10;
  logic [NPAIR-1:0] lo10;
  logic             hi10m;
  logic             lo10m;

  genvar k;
  generate
    for (k = 0; k < NC; k++) begin : g_plain
      assign plain7[k] = ((byte_i ^ cfg_i[k]) & ADDR_BITS) == '0;
    end
    for (k = 0; k < NPAIR; k++) begin : g_pair
      assign mask7[k] = ((byte_i ^ cfg_i[2*k]) & cfg_i[2*k+1] & ADDR_BITS) == '0;
      assign hi10[k]  = ((byte_i ^ cfg_i[2*k+1]) & ADDR_BITS) == '0;
      assign lo10[k]  = (byte_i == cfg_i[2*k]);
    end
  endgenerate

  // masked 10-bit: reg1 high byte under mask reg3, reg0 low byte under mask reg2
  assign hi10m = ((byte_i ^ cfg_i[1]) & cfg_i[3] & ADDR_BITS) == '0;
  assign lo10m = ((byte_i ^ cfg_i[0]) & cfg_i[2]) == '0;

  assign is10_o = mode_i[1];

  always_comb begin
    first_hit_o = '0;
    low_hit_o   = '0;
    case (am_mode_e'(mode_i))
      MODE_7B:      first_hit_o = plain7;
      MODE_7B_MASK: first_hit_o[NPAIR-1:0] = mask7;
      MODE_10B: begin
        first_hit_o[NPAIR-1:0] = hi10;
        low_hit_o              = lo10;
      end
      default: begin
        first_hit_o[0] = hi10m;
        low_hit_o[0]   = lo10m;
      end
    endcase
  end
endmodule

// File: rtl/am_seq.sv
module am_seq
  import am_pkg::*;
#(
  parameter int NC = NCFG,
  localparam int NPAIR  = NC / 2,
  localparam int SLOT_W = $clog2(NC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic              is10_i,
  input  logic [NC-1:0]     first_hit_i,
  input  logic [NPAIR-1:0]  low_hit_i,
  output logic              cap_first_o,
  output logic              cap_low_o,
  output logic              match_o,
  output logic [SLOT_W-1:0] slot_o
);
  am_state_e         state_q, state_d;
  logic [NPAIR-1:0]  cand_q, cand_d;
  logic [SLOT_W-1:0] slot_d;
  logic              match_d;
  logic              upd_en;
  logic [SLOT_W-1:0] first_idx, low_idx;
  logic [NPAIR-1:0]  low_sel;

  // lowest-index priority among hits
  always_comb begin
    first_idx = '0;
    for (int k = NC - 1; k >= 0; k--) begin
      if (first_hit_i[k]) first_idx = SLOT_W'(k);
    end
  end

  assign low_sel = low_hit_i & cand_q;

  always_comb begin
    low_idx = '0;
    for (int k = NPAIR - 1; k >= 0; k--) begin
      if (low_sel[k]) low_idx = SLOT_W'(k);
    end
  end

  assign upd_en = start_i | byte_vld_i;

  always_comb begin
    state_d     = state_q;
    cand_d      = cand_q;
    slot_d      = slot_o;
    match_d     = 1'b0;
    cap_first_o = 1'b0;
    cap_low_o   = 1'b0;
    if (start_i) begin
      state_d = ST_FIRST;
      cand_d  = '0;
    end else if (byte_vld_i) begin
      case (state_q)
        ST_FIRST: begin
          if (|first_hit_i) begin
            cap_first_o = 1'b1;
            if (is10_i) begin
              cand_d  = first_hit_i[NPAIR-1:0];
              state_d = ST_LOW;
            end else begin
              match_d = 1'b1;
              slot_d  = first_idx;
              state_d = ST_DONE;
            end
          end else begin
            state_d = ST_DONE;
          end
        end
        ST_LOW: begin
          if (|low_sel) begin
            cap_low_o = 1'b1;
            match_d   = 1'b1;
            slot_d    = low_idx;
          end
          state_d = ST_DONE;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cand_q  <= '0;
      slot_o  <= '0;
      match_o <= 1'b0;
    end else begin
      match_o <= match_d;
      if (upd_en) begin
        state_q <= state_d;
        cand_q  <= cand_d;
        slot_o  <= slot_d;
      end
    end
  end

  // R10: the match indication lasts exactly one cycle
  p_match_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);

  // R10: a match always follows an accepted byte strobe
  p_match_after_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(byte_vld_i && !start_i));

  // R1: no match can come out of the idle state
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> !match_o);

  // R4: once a decision is made, further bytes raise nothing
  p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> !match_o);

  // R11: a Start always rearms the first-byte comparison
  p_start_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_q == ST_FIRST) && !match_o);
endmodule

// File: rtl/am_capture.sv
module am_capture
  import am_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_i,
  input  logic          is10_i,
  input  logic [BW-1:0] byte_i,
  input  logic          cap_first_i,
  input  logic          cap_low_i,
  output logic [BW-1:0] abuf0_o,
  output logic [BW-1:0] abuf1_o,
  output logic [BW-1:0] rxd_o,
  output logic          rd_o
);
  logic wr_hi, wr_lo;
  logic en_ab0, en_ab1, en_rx, en_rd;

  // a 10-bit first byte is the high byte; a 7-bit byte or 10-bit second byte is low
  assign wr_hi  = cap_first_i & is10_i;
  assign wr_lo  = (cap_first_i & ~is10_i) | cap_low_i;
  assign en_ab0 = wr_lo & ~dir_i;
  assign en_ab1 = wr_hi & ~dir_i;
  assign en_rx  = (wr_lo | wr_hi) & dir_i;
  assign en_rd  = cap_first_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abuf0_o <= '0;
      abuf1_o <= '0;
      rxd_o   <= '0;
      rd_o    <= 1'b0;
    end else begin
      if (en_ab0) abuf0_o <= byte_i;
      if (en_ab1) abuf1_o <= byte_i;
      if (en_rx)  rxd_o   <= byte_i;
      if (en_rd)  rd_o    <= byte_i[0];
    end
  end

  // R9: steering to the buffers leaves the receive register alone
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_first_i || cap_low_i) && !dir_i) |=> $stable(rxd_o));

  // R9: steering to the receive register leaves both buffers alone
  p_abuf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_first_i || cap_low_i) && dir_i) |=> ($stable(abuf0_o) && $stable(abuf1_o)));
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
  import am_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic [1:0] mode_i,
  input  logic       dir_i,
  input  logic [7:0] cfg0_i,
  input  logic [7:0] cfg1_i,
  input  logic [7:0] cfg2_i,
  input  logic [7:0] cfg3_i,
  output logic       match_o,
  output logic [1:0] slot_o,
  output logic       rd_o,
  output logic [7:0] abuf0_o,
  output logic [7:0] abuf1_o,
  output logic [7:0] rxd_o
);
  localparam int NPAIR = NCFG / 2;

  logic rst_meta, rst_int;
  logic [NCFG-1:0][BYTE_W-1:0] cfg;
  logic                        is10;
  logic [NCFG-1:0]             first_hit;
  logic [NPAIR-1:0]            low_hit;
  logic                        cap_first, cap_low;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  assign cfg = {cfg3_i, cfg2_i, cfg1_i, cfg0_i};

  am_cmp_bank #(.BW(BYTE_W), .NC(NCFG)) u_cmp (
    .mode_i      (mode_i),
    .byte_i      (byte_i),
    .cfg_i       (cfg),
    .is10_o      (is10),
    .first_hit_o (first_hit),
    .low_hit_o   (low_hit)
  );

  am_seq #(.NC(NCFG)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int),
    .start_i     (start_i),
    .byte_vld_i  (byte_vld_i),
    .is10_i      (is10),
    .first_hit_i (first_hit),
    .low_hit_i   (low_hit),
    .cap_first_o (cap_first),
    .cap_low_o   (cap_low),
    .match_o     (match_o),
    .slot_o      (slot_o)
  );

  am_capture #(.BW(BYTE_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_int),
    .dir_i       (dir_i),
    .is10_i      (is10),
    .byte_i      (byte_i),
    .cap_first_i (cap_first),
    .cap_low_i   (cap_low),
    .abuf0_o     (abuf0_o),
    .abuf1_o     (abuf1_o),
    .rxd_o       (rxd_o),
    .rd_o        (rd_o)
  );

  // R6: the single masked 10-bit entry is always entry 0
  p_m10_slot_r6: assert property (@(posedge clk) disable iff (!rst_int)
    (match_o && $past(mode_i) == 2'b11) |-> (slot_o == 2'd0));

  // R3: masked 7-bit has only entries 0 and 1
  p_m7_slot_r3: assert property (@(posedge clk) disable iff (!rst_int)
    (match_o && $past(mode_i) == 2'b01) |-> (slot_o[1] == 1'b0));

  // R5: plain 10-bit has only entries 0 and 1
  p_10b_slot_r5: assert property (@(posedge clk) disable iff (!rst_int)
    (match_o && $past(mode_i) == 2'b10) |-> (slot_o[1] == 1'b0));
endmodule

// File: tb/sim_i2c_tgt_addr_match.sv
module sim_i2c_tgt_addr_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic [1:0] mode_i = '0;
  logic       dir_i = 1'b0;
  logic [7:0] cfg [4];
  logic       match_o;
  logic [1:0] slot_o;
  logic       rd_o;
  logic [7:0] abuf0_o, abuf1_o, rxd_o;

  int checks = 0;
  int errors = 0;

  // reference state
  int         ms = 0; // 0 idle, 1 first byte, 2 low byte, 3 done
  logic [1:0] mcand;
  logic [7:0] m_ab0 = '0, m_ab1 = '0, m_rx = '0;
  logic       m_rd = 1'b0;

  always #5 clk = ~clk;

  initial begin
    cfg[0] = '0; cfg[1] = '0; cfg[2] = '0; cfg[3] = '0;
  end

  i2c_tgt_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .mode_i(mode_i), .dir_i(dir_i),
    .cfg0_i(cfg[0]), .cfg1_i(cfg[1]), .cfg2_i(cfg[2]), .cfg3_i(cfg[3]),
    .match_o(match_o), .slot_o(slot_o), .rd_o(rd_o),
    .abuf0_o(abuf0_o), .abuf1_o(abuf1_o), .rxd_o(rxd_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit addr_eq(logic [7:0] a, logic [7:0] b, logic [7:0] m);
    return ((a ^ b) & m & 8'hFE) == 8'h00;
  endfunction

  task automatic model_byte(input logic [7:0] b, output bit em, output int es);
    bit [1:0] hh, lh;
    em = 0; es = 0;
    if (ms == 1) begin
      if (mode_i < 2) begin
        for (int k = 3; k >= 0; k--) begin
          if (mode_i == 2'b00 && addr_eq(b, cfg[k], 8'hFF)) begin em = 1; es = k; end
          if (mode_i == 2'b01 && k < 2 && addr_eq(b, cfg[2*k], cfg[2*k+1])) begin em = 1; es = k; end
        end
        if (em) begin
          m_rd = b[0];
          if (dir_i) m_rx = b; else m_ab0 = b;
        end
        ms = 3;
      end else begin
        hh = '0;
        if (mode_i == 2'b10) begin
          hh[0] = addr_eq(b, cfg[1], 8'hFF);
          hh[1] = addr_eq(b, cfg[3], 8'hFF);
        end else begin
          hh[0] = addr_eq(b, cfg[1], cfg[3]);
        end
        if (hh != 0) begin
          m_rd = b[0];
          if (dir_i) m_rx = b; else m_ab1 = b;
          mcand = hh;
          ms = 2;
        end else begin
          ms = 3;
        end
      end
    end else if (ms == 2) begin
      lh = '0;
      if (mode_i == 2'b10) begin
        lh[0] = (b == cfg[0]) && mcand[0];
        lh[1] = (b == cfg[2]) && mcand[1];
      end else begin
        lh[0] = (((b ^ cfg[0]) & cfg[2]) == 8'h00) && mcand[0];
      end
      if (lh != 0) begin
        em = 1;
        es = lh[0] ? 0 : 1;
        if (dir_i) m_rx = b; else m_ab0 = b;
      end
      ms = 3;
    end
  endtask

  task automatic check_outs(string tag, bit em, int es);
    chk(tag, "match", int'(match_o), int'(em));
    if (em) chk(tag, "slot", int'(slot_o), es);
    chk(tag, "rd", int'(rd_o), int'(m_rd));
    chk(tag, "abuf0", int'(abuf0_o), int'(m_ab0));
    chk(tag, "abuf1", int'(abuf1_o), int'(m_ab1));
    chk(tag, "rxd", int'(rxd_o), int'(m_rx));
  endtask

  task automatic send_start(string tag);
    @(negedge clk);
    start_i = 1'b1;
    ms = 1;
    @(negedge clk);
    start_i = 1'b0;
    chk(tag, "match after start", int'(match_o), 0);
  endtask

  task automatic send_byte(string tag, logic [7:0] b);
    bit em; int es;
    @(negedge clk);
    byte_vld_i = 1'b1;
    byte_i = b;
    model_byte(b, em, es);
    @(negedge clk);
    byte_vld_i = 1'b0;
    check_outs(tag, em, es);
  endtask

  task automatic send_start_byte(string tag, logic [7:0] b);
    @(negedge clk);
    start_i = 1'b1; byte_vld_i = 1'b1; byte_i = b;
    ms = 1;
    @(negedge clk);
    start_i = 1'b0; byte_vld_i = 1'b0;
    check_outs(tag, 1'b0, 0);
  endtask

  function automatic logic [7:0] hit_first(logic [1:0] md);
    int p = $urandom % 2;
    logic [7:0] r = 8'($urandom);
    case (md)
      2'b00: return {cfg[$urandom % 4][7:1], r[0]};
      2'b01: return (cfg[2*p] & cfg[2*p+1]) | (r & ~cfg[2*p+1]);
      2'b10: return {cfg[2*p+1][7:1], r[0]};
      default: return (cfg[1] & cfg[3]) | (r & ~cfg[3]);
    endcase
  endfunction

  function automatic logic [7:0] hit_low(logic [1:0] md);
    logic [7:0] r = 8'($urandom);
    if (md == 2'b10) return cfg[2*($urandom % 2)];
    return (cfg[0] & cfg[2]) | (r & ~cfg[2]);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset values
    check_outs("R12", 1'b0, 0);
    chk("R12", "slot reset", int'(slot_o), 0);

    // R1: byte before any Start is ignored
    mode_i = 2'b00; dir_i = 1'b0;
    cfg[0] = 8'hA0; cfg[1] = 8'h52; cfg[2] = 8'h52; cfg[3] = 8'h7E;
    send_byte("R1", 8'hA1);

    // R2: plain 7-bit, each entry, priority and ignored bit 0 of register
    send_start("R2"); send_byte("R2", 8'hA1);
    send_start("R2"); send_byte("R2", 8'h53);
    send_start("R2"); send_byte("R2", 8'h7F);
    send_start("R2"); send_byte("R2", 8'h10);
    // R4: later byte ignored after a hit
    send_start("R4"); send_byte("R4", 8'hA0); send_byte("R4", 8'h52);

    // R3: masked 7-bit with don't-care bits
    mode_i = 2'b01;
    cfg[0] = 8'hC0; cfg[1] = 8'hF0; cfg[2] = 8'h40; cfg[3] = 8'hFE;
    send_start("R3"); send_byte("R3", 8'hCB);
    send_start("R3"); send_byte("R3", 8'h41);
    send_start("R3"); send_byte("R3", 8'h44);
    send_start("R3"); send_byte("R3", 8'hB0);

    // R5: 10-bit two entries, prefix taken as stored
    mode_i = 2'b10;
    cfg[0] = 8'h3C; cfg[1] = 8'hF2; cfg[2] = 8'h99; cfg[3] = 8'hF6;
    send_start("R5"); send_byte("R5", 8'hF2); send_byte("R5", 8'h3C);
    send_start("R5"); send_byte("R5", 8'hF7); send_byte("R5", 8'h99);
    // R8: high hit, low miss keeps the high capture
    send_start("R8"); send_byte("R8", 8'hF3); send_byte("R8", 8'h99);
    // R7: high miss, matching low byte ignored
    send_start("R7"); send_byte("R7", 8'h02); send_byte("R7", 8'h3C);
    // R11: Restart mid-sequence, and byte together with Start ignored
    send_start("R11"); send_byte("R11", 8'hF6);
    send_start("R11"); send_byte("R11", 8'hF2); send_byte("R11", 8'h3C);
    send_start_byte("R11", 8'hF2); send_byte("R11", 8'hF2); send_byte("R11", 8'h3C);

    // R6: masked 10-bit, R9 with both steering settings
    mode_i = 2'b11;
    cfg[0] = 8'h5A; cfg[1] = 8'hF4; cfg[2] = 8'hF0; cfg[3] = 8'hFC;
    send_start("R6"); send_byte("R6", 8'hF5); send_byte("R6", 8'h53);
    dir_i = 1'b1;
    send_start("R9"); send_byte("R9", 8'hF6); send_byte("R9", 8'h5F);
    mode_i = 2'b00;
    send_start("R9"); send_byte("R9", 8'hF4);
    dir_i = 1'b0;
    send_start("R9"); send_byte("R9", 8'h5B);

    // random transfers
    for (int t = 0; t < 400; t++) begin
      logic [1:0] md = 2'($urandom);
      int nb = 1 + ($urandom % 3);
      mode_i = md;
      dir_i = 1'($urandom);
      for (int k = 0; k < 4; k++) cfg[k] = 8'($urandom);
      if ($urandom % 2) cfg[3][7:3] = 5'b11110;
      send_start(md[1] ? "R5" : "R2");
      for (int i = 0; i < nb; i++) begin
        logic [7:0] b;
        if ($urandom % 4 == 0) b = 8'($urandom);
        else if (i == 0) b = hit_first(md);
        else b = hit_low(md);
        case (md)
          2'b00: send_byte("R2", b);
          2'b01: send_byte("R3", b);
          2'b10: send_byte("R5", b);
          default: send_byte("R6", b);
        endcase
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule